// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block clears a hung I2C bus before the main I2C controller leaves reset. A slave that was interrupted mid-byte can keep SDA low for good; the sequencer clocks SCL until the slave lets go. It then places a start condition followed by a stop condition on the bus, so every device returns to a known idle state. All delays are counted in system clock cycles, computed from a clock-frequency parameter and microsecond settings.

A pulse on `start_i` begins a run. The run first waits for the main controller's transfer-pending flag to clear. It samples the flag a bounded number of times with a gap between samples, and goes on anyway when the attempts run out. It then checks both lines before each clock pulse and stops clocking as soon as both read high, or when the pulse budget is spent. When the start/stop pair has been held, `done_o` rises together with exactly one of `recovered_o` or `failed_o`.

Between runs, software can use the same drive state as a small direct-control view. It forces each line low or releases it, and it reads back the synchronized line levels.

Top module: `i2c_bus_recover`

## Requirements
- R1: After reset, neither line is driven (`scl_oe_o` = `sda_oe_o` = 0), `done_o`, `recovered_o` and `failed_o` are 0, and `reg_rdata_o` reads 4'b1111 on an idle bus.
- R2: When no run is active, a write with `reg_wr_i` loads `reg_wdata_i`, where bit 1 releases SDA and bit 0 releases SCL (1 = release, 0 = drive low). The new drive appears on `sda_oe_o`/`scl_oe_o` in the cycle after the write edge. `reg_rdata_o[3:2]` shows the same two bits.
- R3: `reg_rdata_o[1]` is the SDA level and `reg_rdata_o[0]` the SCL level, each taken through a two-flop synchronizer. A pin change becomes visible in the readback at the second clock edge after it, not the first.
- R4: While `busy_ext_i` is high, the run drives neither line. The flag is sampled up to MAX_POLLS times, with POLL_US between samples. The run continues once the flag is low or the samples are used up.
- R5: Each recovery pulse drives SCL low for exactly PHASE_US and then releases it for exactly PHASE_US. SDA stays released throughout.
- R6: Before each pulse, the synchronized lines are checked. If both read high, no further pulse is issued, so a bus that is already idle gets zero pulses.
- R7: No more than MAX_PULSES pulses are issued in one run. Once the budget is spent, the run proceeds whatever the line levels.
- R8: After clocking, SDA is driven low while SCL is released for exactly HOLD_US (start). Then both are released for exactly HOLD_US (stop) before `done_o` rises.
- R9: With `done_o`, `recovered_o` is 1 if both lines read high at the end of the stop hold, and `failed_o` is 1 otherwise. The two are never set together, and all three flags clear when the next run starts.
- R10: Writes through `reg_wr_i` during an active run have no effect on the line drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Pulse to begin a recovery run (accepted when idle or done) |
| busy_ext_i | input | 1 | Transfer-pending flag from the main controller |
| scl_i | input | 1 | Sampled SCL pin level |
| sda_i | input | 1 | Sampled SDA pin level |
| scl_oe_o | output | 1 | 1 pulls SCL low (open-drain enable) |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| done_o | output | 1 | Run finished; held until next start |
| recovered_o | output | 1 | Bus read idle at end of run |
| failed_o | output | 1 | Bus still held low at end of run |
| reg_wr_i | input | 1 | Direct-control write strobe |
| reg_wdata_i | input | 2 | {SDA release, SCL release} for the direct-control view |
| reg_rdata_o | output | 4 | {SDA release, SCL release, SDA level, SCL level} |

## Verification
The assertions assume that `start_i` arrives only when no run is in progress. They also assume that the pin levels follow the drive enables within a few cycles, as on a wired-AND bus, so the synchronized view is settled by the end of every phase. The stimulus models the bus as a wired-AND of the block's enables and a simulated slave. The slave holds SDA low for a chosen number of SCL falling edges, or holds SCL low for the whole run. Every phase is set well above the synchronizer latency, and each run is started only after the previous `done_o`.

// File: rtl/i2c_rec_pkg.sv
// Shared types and helpers for the I2C bus recovery sequencer.
// Assumes callers pass a clock frequency in Hz and delays in microseconds.
package i2c_rec_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_POLL,
        ST_POLL_WAIT,
        ST_CHECK,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_START,
        ST_STOP,
        ST_DONE
    } rec_state_e;

    // Convert a delay in microseconds to clock cycles, never less than one.
    function automatic int unsigned us_cycles(input int unsigned clk_hz,
                                              input int unsigned us);
        longint unsigned c;
        c = (longint'(clk_hz) * longint'(us)) / 64'd1000000;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

    // Largest of three cycle counts, used to size the shared timer.
    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
// Two-flop synchronizer for a group of asynchronous pin levels.
// Assumes the pins idle high, so the flops reset to 1.
module i2c_line_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            logic meta_q, stab_q;
            // Two-stage capture of one pin level.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b1;
                    stab_q <= 1'b1;
                end else begin
                    meta_q <= din[i];
                    stab_q <= meta_q;
                end
            end
            assign dout[i] = stab_q;
        end
    endgenerate

endmodule

// File: rtl/i2c_rec_timer.sv
// Shared down-counter for all phase, hold and poll delays.
// A load of D-1 makes the owning state last exactly D cycles; zero_o is
// high once the count has run out, and stays high until the next load.
module i2c_rec_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    // Load on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load_i)        cnt_q <= load_val_i;
        else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/i2c_rec_fsm.sv
// Recovery sequencer control: polls the pending flag, clocks SCL while the
// bus is held, then issues a start/stop pair and grades the result.
// Assumes scl_s_i/sda_s_i are already synchronized and the timer is shared.
module i2c_rec_fsm
    import i2c_rec_pkg::*;
#(
    parameter int TW         = 8,
    parameter int PHASE_CYC  = 4,
    parameter int HOLD_CYC   = 8,
    parameter int POLL_CYC   = 8,
    parameter int MAX_PULSES = 10,
    parameter int MAX_POLLS  = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          busy_i,
    input  logic          scl_s_i,
    input  logic          sda_s_i,
    input  logic          tmr_zero_i,
    output logic          tmr_load_o,
    output logic [TW-1:0] tmr_val_o,
    output logic          drv_we_o,
    output logic [1:0]    drv_val_o,
    output logic          active_o,
    output logic          in_poll_o,
    output logic          done_o,
    output logic          recovered_o,
    output logic          failed_o
);

    localparam int PW = $clog2(MAX_PULSES + 1);
    localparam int QW = $clog2(MAX_POLLS + 1);
    localparam logic [TW-1:0] PHASE_V = TW'(PHASE_CYC - 1);
    localparam logic [TW-1:0] HOLD_V  = TW'(HOLD_CYC - 1);
    localparam logic [TW-1:0] POLL_V  = TW'(POLL_CYC - 1);

    rec_state_e    state_q, state_d;
    logic [PW-1:0] pulse_q;
    logic [QW-1:0] poll_q;
    logic          pulse_inc, poll_inc, seq_clear, seq_finish;
    logic          bus_idle;

    assign bus_idle = scl_s_i & sda_s_i;

    // Next state, timer loads and drive updates ({sda_rel, scl_rel}).
    always_comb begin
        state_d    = state_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        drv_we_o   = 1'b0;
        drv_val_o  = 2'b11;
        pulse_inc  = 1'b0;
        poll_inc   = 1'b0;
        seq_clear  = 1'b0;
        seq_finish = 1'b0;
        case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    state_d   = ST_POLL;
                    drv_we_o  = 1'b1;
                    seq_clear = 1'b1;
                end
            end
            ST_POLL: begin
                if (!busy_i) begin
                    state_d = ST_CHECK;
                end else begin
                    poll_inc   = 1'b1;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = POLL_V;
                    state_d    = ST_POLL_WAIT;
                end
            end
            ST_POLL_WAIT: begin
                if (tmr_zero_i)
                    state_d = (poll_q == QW'(MAX_POLLS)) ? ST_CHECK : ST_POLL;
            end
            ST_CHECK, ST_CLK_HI: begin
                if (state_q == ST_CHECK || tmr_zero_i) begin
                    drv_we_o   = 1'b1;
                    tmr_load_o = 1'b1;
                    if (bus_idle || pulse_q == PW'(MAX_PULSES)) begin
                        state_d   = ST_START;
                        drv_val_o = 2'b01;
                        tmr_val_o = HOLD_V;
                    end else begin
                        state_d   = ST_CLK_LO;
                        drv_val_o = 2'b10;
                        tmr_val_o = PHASE_V;
                        pulse_inc = 1'b1;
                    end
                end
            end
            ST_CLK_LO: begin
                if (tmr_zero_i) begin
                    state_d    = ST_CLK_HI;
                    drv_we_o   = 1'b1;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = PHASE_V;
                end
            end
            ST_START: begin
                if (tmr_zero_i) begin
                    state_d    = ST_STOP;
                    drv_we_o   = 1'b1;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = HOLD_V;
                end
            end
            ST_STOP: begin
                if (tmr_zero_i) begin
                    state_d    = ST_DONE;
                    seq_finish = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, counters and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            pulse_q     <= '0;
            poll_q      <= '0;
            recovered_o <= 1'b0;
            failed_o    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (seq_clear) begin
                pulse_q     <= '0;
                poll_q      <= '0;
                recovered_o <= 1'b0;
                failed_o    <= 1'b0;
            end else begin
                if (pulse_inc) pulse_q <= pulse_q + PW'(1);
                if (poll_inc)  poll_q  <= poll_q + QW'(1);
                if (seq_finish) begin
                    recovered_o <= bus_idle;
                    failed_o    <= ~bus_idle;
                end
            end
        end
    end

    assign done_o    = (state_q == ST_DONE);
    assign active_o  = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign in_poll_o = (state_q == ST_POLL) || (state_q == ST_POLL_WAIT);

endmodule

// File: rtl/i2c_bus_recover.sv
// I2C bus recovery sequencer top: synchronizes the pins, owns the shared
// line-drive register (also the software direct-control view) and the timer.
// Assumes open-drain pads: an *_oe_o of 1 pulls the line low.
module i2c_bus_recover
    import i2c_rec_pkg::*;
#(
    parameter int CLK_HZ     = 100000000,
    parameter int PHASE_US   = 100,
    parameter int HOLD_US    = 1000,
    parameter int POLL_US    = 500,
    parameter int MAX_PULSES = 10,
    parameter int MAX_POLLS  = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       busy_ext_i,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe_o,
    output logic       sda_oe_o,
    output logic       done_o,
    output logic       recovered_o,
    output logic       failed_o,
    input  logic       reg_wr_i,
    input  logic [1:0] reg_wdata_i,
    output logic [3:0] reg_rdata_o
);

    localparam int PHASE_CYC = us_cycles(CLK_HZ, PHASE_US);
    localparam int HOLD_CYC  = us_cycles(CLK_HZ, HOLD_US);
    localparam int POLL_CYC  = us_cycles(CLK_HZ, POLL_US);
    localparam int TW        = $clog2(max3(PHASE_CYC, HOLD_CYC, POLL_CYC) + 1);

    logic [1:0]    lines_s;     // {sda, scl} synchronized
    logic [1:0]    drv_q;       // {sda_rel, scl_rel}
    logic          seq_we, seq_active, seq_in_poll;
    logic [1:0]    seq_val;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;

    i2c_line_sync #(.N(2)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sda_i, scl_i}),
        .dout (lines_s)
    );

    i2c_rec_timer #(.W(TW)) tmr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .zero_o    (tmr_zero)
    );

    i2c_rec_fsm #(
        .TW        (TW),
        .PHASE_CYC (PHASE_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .POLL_CYC  (POLL_CYC),
        .MAX_PULSES(MAX_PULSES),
        .MAX_POLLS (MAX_POLLS)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .busy_i     (busy_ext_i),
        .scl_s_i    (lines_s[0]),
        .sda_s_i    (lines_s[1]),
        .tmr_zero_i (tmr_zero),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .drv_we_o   (seq_we),
        .drv_val_o  (seq_val),
        .active_o   (seq_active),
        .in_poll_o  (seq_in_poll),
        .done_o     (done_o),
        .recovered_o(recovered_o),
        .failed_o   (failed_o)
    );

    // Line-drive register: sequencer has priority, software only when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                        drv_q <= 2'b11;
        else if (seq_we)                   drv_q <= seq_val;
        else if (reg_wr_i && !seq_active)  drv_q <= reg_wdata_i;
    end

    assign scl_oe_o    = ~drv_q[0];
    assign sda_oe_o    = ~drv_q[1];
    assign reg_rdata_o = {drv_q, lines_s};

endmodule

// File: rtl/i2c_bus_recover_chk.sv
// Property checker for the recovery sequencer, bound to the top module.
// Assumes start_i is only pulsed while no run is active.
module i2c_bus_recover_chk #(
    parameter int MAX_PULSES = 10
) (
    input logic clk,
    input logic rst_n,
    input logic active,
    input logic seq_we,
    input logic in_poll,
    input logic scl_oe,
    input logic sda_oe,
    input logic done,
    input logic recovered,
    input logic failed
);

    int unsigned pulse_seen;
    logic        scl_oe_q;

    // Count SCL pull-downs within one run, independent of the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_seen <= 0;
            scl_oe_q   <= 1'b0;
        end else begin
            scl_oe_q <= scl_oe;
            if (!active)                 pulse_seen <= 0;
            else if (scl_oe && !scl_oe_q) pulse_seen <= pulse_seen + 1;
        end
    end

    assert_no_drive_in_poll_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_poll |-> (!scl_oe && !sda_oe));

    assert_sda_free_in_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && scl_oe) |-> !sda_oe);

    assert_pulse_budget_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_seen <= MAX_PULSES);

    assert_start_scl_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $rose(sda_oe)) |-> !scl_oe);

    assert_one_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $countones({recovered, failed}) == 1);

    assert_flags_clear_in_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (!done && !recovered && !failed));

    assert_sw_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !seq_we) |=> $stable({scl_oe, sda_oe}));

endmodule

bind i2c_bus_recover i2c_bus_recover_chk #(.MAX_PULSES(MAX_PULSES)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (seq_active),
    .seq_we   (seq_we),
    .in_poll  (seq_in_poll),
    .scl_oe   (scl_oe_o),
    .sda_oe   (sda_oe_o),
    .done     (done_o),
    .recovered(recovered_o),
    .failed   (failed_o)
);

// File: tb/i2c_bus_recover_tb_top.sv
// Scoreboard bench: the driver pushes the expected outcome of each run, a
// monitor measures the bus activity and compares at done_o.
module i2c_bus_recover_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 1000000;
    localparam int PHASE      = 5;
    localparam int HOLD       = 12;
    localparam int POLL       = 7;
    localparam int MP         = 10;
    localparam int MPOLL      = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       busy_ext_i = 1'b0;
    logic       scl_oe_o, sda_oe_o, done_o, recovered_o, failed_o;
    logic       reg_wr_i = 1'b0;
    logic [1:0] reg_wdata_i = 2'b11;
    logic [3:0] reg_rdata_o;
    logic       scl_i, sda_i;

    // Simulated slave
    int  slave_k = 0;
    int  slave_cnt = 0;
    bit  scl_stuck = 1'b0;
    logic slave_scl_q = 1'b0;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  run_on = 1'b0;

    typedef struct {
        string tag;
        int    pulses;
        bit    rec;
        int    lat_min;
        int    lat_max;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl_i = !scl_oe_o && !scl_stuck;
    assign sda_i = !sda_oe_o && (slave_cnt >= slave_k);

    i2c_bus_recover #(
        .CLK_HZ(CLK_HZ), .PHASE_US(PHASE), .HOLD_US(HOLD), .POLL_US(POLL),
        .MAX_PULSES(MP), .MAX_POLLS(MPOLL)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_ext_i(busy_ext_i),
        .scl_i(scl_i), .sda_i(sda_i), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
        .done_o(done_o), .recovered_o(recovered_o), .failed_o(failed_o),
        .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Slave counts SCL falling edges; restarts on each run start.
    always @(negedge clk) begin
        if (start_i) slave_cnt <= 0;
        else if (scl_oe_o && !slave_scl_q) slave_cnt <= slave_cnt + 1;
        slave_scl_q <= scl_oe_o;
    end

    // Monitor: measures latency, pulse widths, holds; pops at done.
    int lat, pulses, lo_cnt, hi_cnt, sda_cnt, stop_cnt;
    bit lat_arm, hi_trk, stop_trk;
    logic p_scl = 1'b0, p_sda = 1'b0, p_done = 1'b0;
    always @(negedge clk) begin
        if (run_on) begin
            if (start_i) begin
                lat = 0; lat_arm = 1; pulses = 0; hi_trk = 0; stop_trk = 0;
            end else begin
                if (lat_arm) begin
                    lat++;
                    if ((scl_oe_o && !p_scl) || (sda_oe_o && !p_sda)) begin
                        check(lat >= exp_q[0].lat_min && lat <= exp_q[0].lat_max,
                              {"R4 start latency ", exp_q[0].tag}, lat, exp_q[0].lat_min);
                        lat_arm = 0;
                    end
                end
                if (scl_oe_o && !p_scl) begin
                    pulses++; lo_cnt = 1;
                    if (hi_trk) check(hi_cnt == PHASE, "R5 high phase", hi_cnt, PHASE);
                    hi_trk = 0;
                end else if (scl_oe_o) lo_cnt++;
                else if (p_scl) begin
                    check(lo_cnt == PHASE, "R5 low phase", lo_cnt, PHASE);
                    hi_trk = 1; hi_cnt = 1;
                end else if (hi_trk && !sda_oe_o) hi_cnt++;
                if (sda_oe_o && !p_sda) begin
                    check(!scl_oe_o, "R8 start with SCL released", scl_oe_o, 0);
                    if (hi_trk) check(hi_cnt == PHASE, "R5 last high phase", hi_cnt, PHASE);
                    hi_trk = 0; sda_cnt = 1;
                end else if (sda_oe_o) sda_cnt++;
                else if (p_sda) begin
                    check(sda_cnt == HOLD, "R8 start hold", sda_cnt, HOLD);
                    stop_trk = 1; stop_cnt = 1;
                end else if (stop_trk && !done_o) stop_cnt++;
                if (done_o && !p_done) begin
                    check(stop_trk && stop_cnt == HOLD, "R8 stop hold", stop_cnt, HOLD);
                    stop_trk = 0;
                    if (exp_q.size() == 0) begin
                        check(0, "scoreboard empty", 0, 1);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(pulses == e.pulses, {"R6 R7 pulse count ", e.tag}, pulses, e.pulses);
                        check(recovered_o == e.rec && failed_o == !e.rec,
                              {"R9 result ", e.tag}, {recovered_o, failed_o}, {e.rec, !e.rec});
                    end
                end
            end
        end
        p_scl = scl_oe_o; p_sda = sda_oe_o; p_done = done_o;
    end

    // Driver: one recovery run with a given bus fault and busy pattern.
    task automatic run_seq(input string tag, input int k, input bit scl_stk,
                           input int busy_cyc, input bit busy_forever, input bit poke);
        exp_t e;
        e.tag     = tag;
        e.pulses  = scl_stk ? MP : ((k > MP) ? MP : k);
        e.rec     = !scl_stk && (k <= MP);
        e.lat_min = busy_forever ? MPOLL*POLL : ((busy_cyc > 0) ? busy_cyc - 2 : 1);
        e.lat_max = busy_forever ? MPOLL*(POLL+1) + 5 :
                    ((busy_cyc > 0) ? busy_cyc + POLL + 6 : 5);
        exp_q.push_back(e);
        @(posedge clk); #1;
        slave_k = k; scl_stuck = scl_stk; run_on = 1'b1;
        busy_ext_i = (busy_cyc > 0) || busy_forever;
        start_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0;
        @(negedge clk);
        check(!done_o && !recovered_o && !failed_o, {"R9 flags cleared ", tag},
              {done_o, recovered_o, failed_o}, 0);
        if (busy_cyc > 0 && !busy_forever) begin
            repeat (busy_cyc - 1) @(posedge clk);
            #1 busy_ext_i = 1'b0;
        end
        if (poke) begin
            wait (sda_oe_o);
            @(posedge clk); #1 reg_wr_i = 1'b1; reg_wdata_i = 2'b11;
            @(posedge clk); #1 reg_wr_i = 1'b0;
            @(negedge clk);
            check(sda_oe_o && !scl_oe_o, "R10 write ignored in run",
                  {sda_oe_o, scl_oe_o}, 2'b10);
        end
        wait (done_o);
        @(posedge clk); #1;
        busy_ext_i = 1'b0; run_on = 1'b0; slave_k = 0; scl_stuck = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    // Direct-control write and readback through the synchronizer.
    task automatic reg_test(input logic [1:0] wval);
        @(posedge clk); #1 reg_wr_i = 1'b1; reg_wdata_i = wval;
        @(posedge clk); #1 reg_wr_i = 1'b0;
        @(negedge clk);
        check(sda_oe_o == !wval[1] && scl_oe_o == !wval[0], "R2 drive follows write",
              {sda_oe_o, scl_oe_o}, ~wval);
        check(reg_rdata_o[3:2] == wval, "R2 readback of drive bits", reg_rdata_o[3:2], wval);
        check(reg_rdata_o[1:0] == 2'b11, "R3 sync lag stage 1", reg_rdata_o[1:0], 2'b11);
        @(negedge clk);
        check(reg_rdata_o[1:0] == 2'b11, "R3 sync lag stage 2", reg_rdata_o[1:0], 2'b11);
        @(negedge clk);
        check(reg_rdata_o == {wval, wval}, "R3 line levels visible", reg_rdata_o, {wval, wval});
        @(posedge clk); #1 reg_wr_i = 1'b1; reg_wdata_i = 2'b11;
        @(posedge clk); #1 reg_wr_i = 1'b0;
        repeat (4) @(posedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!scl_oe_o && !sda_oe_o && !done_o && !recovered_o && !failed_o,
              "R1 outputs after reset", {scl_oe_o, sda_oe_o, done_o, recovered_o, failed_o}, 0);
        check(reg_rdata_o == 4'hF, "R1 readback after reset", reg_rdata_o, 4'hF);

        reg_test(2'b01);   // SDA low, SCL released
        reg_test(2'b10);   // SCL low, SDA released

        run_seq("idle bus", 0, 1'b0, 0, 1'b0, 1'b1);
        run_seq("sda held 3", 3, 1'b0, 0, 1'b0, 1'b0);
        run_seq("sda held 10", 10, 1'b0, 0, 1'b0, 1'b0);
        run_seq("sda held 15", 15, 1'b0, 0, 1'b0, 1'b0);
        run_seq("scl held", 0, 1'b1, 0, 1'b0, 1'b0);
        run_seq("busy 20", 2, 1'b0, 20, 1'b0, 1'b0);
        run_seq("busy forever", 0, 1'b0, 0, 1'b1, 1'b0);

        reg_test(2'b01);   // software view usable again after a run

        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule